// File: doc/BRIEF.md
# Multi-Detection 10-Bit Character Aligner

The aligner sits after a deserializer that hands over ten new line bits per character clock. It keeps the previous nine bits as history, so every cycle it can examine each of the ten possible character boundaries in a 19-bit window. At each boundary it looks for a selectable framing pattern in either running-disparity form. It moves its boundary only after repeated sightings on one and the same offset. The character clock itself is never touched: realignment only changes which ten window bits are registered as the output character, so exactly one character leaves per cycle whatever happens.

Two confirmation rules are offered. The span rule needs two sightings on one offset no more than 50 bits apart, which means a spacing of at most four character times. The run rule needs four sightings on one offset in back-to-back characters. A sighting on a different offset throws away the pending candidate and starts a new one. A global enable freezes the boundary. The outputs are the aligned character, a flag that marks a framing character, and a one-cycle pulse when the boundary moves.

Top module: `char_aligner`

## Requirements
- R1: With modeSel=0 (span rule), a sighting on the pending offset one to four characters after the first sighting confirms that offset. The character that confirms is then output already aligned to the new offset.
- R2: With modeSel=0, two sightings five or more characters apart do not confirm. The later sighting starts a new candidate instead.
- R3: With modeSel=1 (run rule), the offset is confirmed on the fourth sighting in consecutive characters on that offset. A character without a sighting clears the count.
- R4: A sighting on an offset that differs from the pending candidate replaces the candidate and restarts its count or span.
- R5: While frameEn is 0, the boundary does not change and outRealign stays 0, even when framing characters are present.
- R6: One character is output per clock cycle, registered one edge after its last bit arrives. Offset k (0..9) selects window bits [18-k:9-k] of {previous rawIn[8:0], rawIn}. rawIn[9] is the first bit received and becomes outChar[9].
- R7: outFrame is 1 exactly when outChar is the selected framing pattern. With patSel=0 this means outChar[9:3] is 0011111 or 1100000. With patSel=1 it means outChar is 0011111010 or 1100000101.
- R8: outRealign pulses for one cycle, in the cycle the first realigned character is output, and only when the confirmed offset differs from the current one.
- R9: Reset gives offset 9 (the word as delivered), zero history, and outChar, outFrame and outRealign all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameEn | input | 1 | Allows boundary changes when 1 |
| modeSel | input | 1 | 0 span rule, 1 run rule |
| patSel | input | 1 | 0 seven-bit comma, 1 full ten-bit comma character |
| rawIn | input | 10 | Ten new line bits, bit 9 received first |
| outChar | output | 10 | Aligned character |
| outFrame | output | 1 | Output character is the framing pattern |
| outRealign | output | 1 | One-cycle pulse on a boundary change |

## Verification
All three outputs are registered, so each one reflects the rawIn word applied before the next rising edge and shows that word's aligned character at that edge. A confirmation therefore shows up on the same edge as the character that completed it. The bench drives each word on the falling edge and samples one nanosecond after the following rising edge. It compares outChar, outFrame and outRealign every cycle against a bit-stream model with a known comma placement. That model tracks the expected offset, switching it exactly in the cycle the vector table names as the lock cycle.

// File: rtl/char_aligner_pkg.sv
package char_aligner_pkg;
  localparam int CHAR_W = 10;
  localparam int OFF_W  = $clog2(CHAR_W);
  localparam int WIN_W  = 2 * CHAR_W - 1;
  localparam int CMA_W  = 7;

  localparam logic [CMA_W-1:0]  COMMA_P = 7'b0011111;
  localparam logic [CMA_W-1:0]  COMMA_N = 7'b1100000;
  localparam logic [CHAR_W-1:0] KCHR_P  = 10'b0011111010;
  localparam logic [CHAR_W-1:0] KCHR_N  = 10'b1100000101;

  typedef struct packed {
    logic             load;
    logic [OFF_W-1:0] offset;
  } alignStrobe_t;

  function automatic logic isFramePat(input logic [CHAR_W-1:0] c, input logic fullChar);
    if (fullChar) return (c == KCHR_P) || (c == KCHR_N);
    return (c[CHAR_W-1 -: CMA_W] == COMMA_P) || (c[CHAR_W-1 -: CMA_W] == COMMA_N);
  endfunction
endpackage

// File: rtl/char_aligner_dp.sv
module char_aligner_dp
  import char_aligner_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] rawIn,
  input  logic              patSel,
  input  alignStrobe_t      strobe,
  output logic              hitAny,
  output logic [OFF_W-1:0]  hitOff,
  output logic [CHAR_W-1:0] outChar,
  output logic              outFrame,
  output logic              outRealign
);
  logic [CHAR_W-2:0] histReg;
  logic [WIN_W-1:0]  win;
  logic [CHAR_W-1:0] slice [CHAR_W];
  logic [CHAR_W-1:0] hitVec;
  logic [OFF_W-1:0]  curOff;
  logic [OFF_W-1:0]  nextOff;

  assign win = {histReg, rawIn};

  for (genvar k = 0; k < CHAR_W; k++) begin : g_off
    assign slice[k]  = win[WIN_W-1-k -: CHAR_W];
    assign hitVec[k] = isFramePat(slice[k], patSel);
  end

  // lowest offset wins when several boundaries match
  always_comb begin
    hitOff = '0;
    for (int k = CHAR_W - 1; k >= 0; k--) begin
      if (hitVec[k]) hitOff = OFF_W'(k);
    end
  end
  assign hitAny  = |hitVec;
  assign nextOff = strobe.load ? strobe.offset : curOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histReg    <= '0;
      curOff     <= OFF_W'(CHAR_W - 1);
      outChar    <= '0;
      outFrame   <= 1'b0;
      outRealign <= 1'b0;
    end else begin
      histReg    <= rawIn[CHAR_W-2:0];
      curOff     <= nextOff;
      outChar    <= slice[nextOff];
      outFrame   <= isFramePat(slice[nextOff], patSel);
      outRealign <= strobe.load && (strobe.offset != curOff);
    end
  end

  p_pulse_moves_r8: assert property (@(posedge clk) disable iff (!rstN)
    outRealign |-> (curOff != $past(curOff)));
  p_hold_offset_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.load) |-> (curOff == $past(curOff)));
  p_offset_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    curOff < OFF_W'(CHAR_W));
endmodule

// File: rtl/char_aligner_ctrl.sv
module char_aligner_ctrl
  import char_aligner_pkg::*;
#(
  parameter int WIN_BITS = 50,
  parameter int RUN_LEN  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameEn,
  input  logic             modeSel,
  input  logic             hitAny,
  input  logic [OFF_W-1:0] hitOff,
  output alignStrobe_t     strobe
);
  localparam int MAX_GAP = WIN_BITS / CHAR_W - 1;
  localparam int CNT_MAX = (MAX_GAP > RUN_LEN) ? MAX_GAP : RUN_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             pendValid, nValid;
  logic [OFF_W-1:0] pendOff, nOff;
  logic [CNT_W-1:0] cnt, nCnt;
  logic             sameOff, confirm;

  assign sameOff = pendValid && hitAny && (hitOff == pendOff);

  always_comb begin
    confirm = 1'b0;
    nValid  = pendValid;
    nOff    = pendOff;
    nCnt    = cnt;
    if (!frameEn) begin
      nValid = 1'b0;
    end else if (!modeSel) begin
      // span rule: cnt is character distance since the first sighting
      if (sameOff) begin
        confirm = 1'b1;
        nValid  = 1'b0;
      end else if (hitAny) begin
        nValid = 1'b1;
        nOff   = hitOff;
        nCnt   = CNT_W'(1);
      end else if (pendValid) begin
        if (cnt == CNT_W'(MAX_GAP)) nValid = 1'b0;
        else                        nCnt   = cnt + 1'b1;
      end
    end else begin
      // run rule: cnt is the number of back-to-back sightings
      if (sameOff) begin
        if (cnt == CNT_W'(RUN_LEN - 1)) begin
          confirm = 1'b1;
          nValid  = 1'b0;
        end else begin
          nCnt = cnt + 1'b1;
        end
      end else if (hitAny) begin
        nValid = 1'b1;
        nOff   = hitOff;
        nCnt   = CNT_W'(1);
      end else begin
        nValid = 1'b0;
      end
    end
  end

  assign strobe.load   = confirm;
  assign strobe.offset = hitOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendOff   <= '0;
      cnt       <= '0;
    end else begin
      pendValid <= nValid;
      pendOff   <= nOff;
      cnt       <= nCnt;
    end
  end

  p_load_on_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (hitAny && pendValid));
  p_disabled_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    !frameEn |=> !pendValid);
  p_span_limit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !modeSel) |-> (cnt <= CNT_W'(MAX_GAP)));
  p_run_history_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && modeSel) |-> ($past(hitAny) && $past(hitAny, 2) && $past(hitAny, 3)));
endmodule

// File: rtl/char_aligner.sv
module char_aligner
  import char_aligner_pkg::*;
#(
  parameter int WIN_BITS = 50,
  parameter int RUN_LEN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameEn,
  input  logic              modeSel,
  input  logic              patSel,
  input  logic [CHAR_W-1:0] rawIn,
  output logic [CHAR_W-1:0] outChar,
  output logic              outFrame,
  output logic              outRealign
);
  alignStrobe_t     strobe;
  logic             hitAny;
  logic [OFF_W-1:0] hitOff;

  char_aligner_dp u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .patSel(patSel), .strobe(strobe),
    .hitAny(hitAny), .hitOff(hitOff), .outChar(outChar), .outFrame(outFrame),
    .outRealign(outRealign)
  );

  char_aligner_ctrl #(.WIN_BITS(WIN_BITS), .RUN_LEN(RUN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameEn(frameEn), .modeSel(modeSel),
    .hitAny(hitAny), .hitOff(hitOff), .strobe(strobe)
  );
endmodule

// File: tb/char_aligner_bench.sv
module char_aligner_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       frameEn, modeSel, patSel;
  logic [9:0] rawIn;
  logic [9:0] outChar;
  logic       outFrame, outRealign;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  char_aligner u_char_aligner (
    .clk(clk), .rstN(rstN), .frameEn(frameEn), .modeSel(modeSel), .patSel(patSel),
    .rawIn(rawIn), .outChar(outChar), .outFrame(outFrame), .outRealign(outRealign)
  );

  // kind 0: 0011111010, kind 1: 1100000101, kind 2: 0011111000
  typedef struct packed {
    logic        mode;
    logic        pat;
    logic [1:0]  kind;
    logic [3:0]  phase;
    logic [11:0] mask;
    logic [3:0]  tLock;
    logic [3:0]  enOff;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 4'd3, 12'b0000_0010_0100, 4'd6,  4'd15},
    '{1'b0, 1'b0, 2'd0, 4'd3, 12'b0100_0100_0010, 4'd11, 4'd15},
    '{1'b0, 1'b0, 2'd1, 4'd7, 12'b0000_0000_1100, 4'd4,  4'd15},
    '{1'b1, 1'b0, 2'd0, 4'd5, 12'b0011_1100_1110, 4'd10, 4'd15},
    '{1'b1, 1'b0, 2'd1, 4'd2, 12'b0000_0001_1111, 4'd4,  4'd15},
    '{1'b0, 1'b0, 2'd0, 4'd4, 12'b0000_0000_1100, 4'd0,  4'd0},
    '{1'b0, 1'b0, 2'd0, 4'd0, 12'b0000_0000_0110, 4'd0,  4'd15},
    '{1'b0, 1'b1, 2'd0, 4'd6, 12'b0000_0001_1000, 4'd5,  4'd15},
    '{1'b0, 1'b1, 2'd2, 4'd8, 12'b0000_0000_1100, 4'd0,  4'd15},
    '{1'b1, 1'b0, 2'd2, 4'd1, 12'b0000_0111_1000, 4'd7,  4'd15}
  };
  string tags [NV] = '{"R1", "R2", "R1", "R3", "R3", "R5", "R8", "R7", "R7", "R3"};

  logic streamBits [0:159];

  function automatic logic [9:0] kindChar(input int kind);
    case (kind)
      0:       return 10'b0011111010;
      1:       return 10'b1100000101;
      default: return 10'b0011111000;
    endcase
  endfunction

  function automatic logic refFrame(input logic [9:0] c, input logic full);
    if (full) return (c == 10'b0011111010) || (c == 10'b1100000101);
    return (c[9:3] == 7'b0011111) || (c[9:3] == 7'b1100000);
  endfunction

  function automatic logic getBit(input int i);
    if (i < 0) return 1'b0;
    return streamBits[i];
  endfunction

  task automatic putChar(input int pos, input logic [9:0] c);
    for (int b = 0; b < 10; b++) streamBits[pos + b] = c[9 - b];
  endtask

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; rawIn = '0; frameEn = 1'b0; modeSel = 1'b0; patSel = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(outChar == 10'd0 && !outFrame && !outRealign, "R9", "reset outputs",
          {outFrame, outRealign, outChar}, 12'h000);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runScen(input vec_t v, input string tag, input int exPos,
                         input int exCount, input int exKind);
    int offExp;
    logic [9:0] expC;
    for (int i = 0; i < 160; i++) streamBits[i] = (i % 2 == 0);
    for (int j = 0; j < 12; j++)
      if (v.mask[j]) putChar(int'(v.phase) + 10 * j, kindChar(int'(v.kind)));
    for (int i = 0; i < exCount; i++) putChar(exPos + 10 * i, kindChar(exKind));
    doReset();
    offExp = 9;
    for (int t = 0; t < 14; t++) begin
      @(negedge clk);
      frameEn = (t < int'(v.enOff));
      modeSel = v.mode;
      patSel  = v.pat;
      for (int b = 0; b < 10; b++) rawIn[9 - b] = getBit(10 * t + b);
      @(posedge clk);
      #1;
      if (v.tLock != 0 && t == int'(v.tLock)) offExp = (int'(v.phase) + 9) % 10;
      for (int b = 0; b < 10; b++) expC[9 - b] = getBit(10 * t - 9 + offExp + b);
      check(outChar == expC, tag, "R6 char", {2'b0, outChar}, {2'b0, expC});
      check(outFrame == refFrame(expC, v.pat), tag, "R7 flag",
            {11'b0, outFrame}, {11'b0, refFrame(expC, v.pat)});
      check(outRealign == (v.tLock != 0 && t == int'(v.tLock)), tag, "R8 pulse",
            {11'b0, outRealign}, {11'b0, (v.tLock != 0 && t == int'(v.tLock))});
    end
  endtask

  initial begin
    vec_t dv;
    for (int n = 0; n < NV; n++) runScen(VECS[n], tags[n], 0, 0, 0);
    // R4: span candidate on phase 3 interrupted by a sighting on phase 6
    dv = '{1'b0, 1'b0, 2'd0, 4'd3, 12'b0000_0001_0010, 4'd0, 4'd15};
    runScen(dv, "R4", 26, 1, 0);
    // R5: lock on phase 3, then disable and offer commas on phase 6
    dv = '{1'b0, 1'b0, 2'd0, 4'd3, 12'b0000_0000_1100, 4'd4, 4'd6};
    runScen(dv, "R5", 66, 2, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule